// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits between a two-master channel selector and the shared downstream I2C segment. The selector asks for a channel change by pulsing a request and naming the target channel. If recovery is enabled, the block takes the downstream SCL and SDA lines and drives a fixed pattern on them before the new master is connected. The pattern has nine free clock pulses with SDA released, one extra pulse that acts as a not-acknowledge, and a STOP condition. Any slave that was stuck in the middle of a byte ends up idle. Only after the pattern ends does the block tell the selector to close the switch, and it sends a completion interrupt to the master that now owns the bus.

Both lines are open-drain. Each output is a drive-low enable, and a released line reads high through its pull-up. The length of each SCL half-period is a parameter counted in system clocks. The default of 250 gives 100 kHz from a 50 MHz clock. During SCL-high phases the block reads SCL back and waits while a slave holds it low. When recovery is disabled, the switch completes on the clock after the request and the lines are never driven.

Top module: `i2c_recovery_seq`

## Requirements
- R1: With recovery disabled, a request accepted while idle gives `connect_o` high for exactly one cycle, on the cycle after the request edge. `connect_chan_o` then equals the requested channel, `busy_o` stays low and both drive enables stay low.
- R2: With recovery enabled, the sequence starts with NUM_PULSES (default nine) SCL pulses, each made of one low half-period (`scl_oe_o`=1) followed by one high half-period (`scl_oe_o`=0), with `sda_oe_o`=0 throughout. Each half-period lasts HALF_DIV clocks.
- R3: After those pulses comes one more SCL pulse with SDA released (not-acknowledge). In total, SCL is released NUM_PULSES+1 times while SDA is released.
- R4: The sequence ends with a STOP made of three half-periods, in this order: SCL low with SDA driven low, then SCL released with SDA driven low, then both released. SDA is never newly driven low while SCL is released.
- R5: `connect_o` pulses, and `connect_chan_o` takes the target channel, only on the cycle after the last half-period ends, together with the fall of `busy_o`. Without stretching, `busy_o` stays high for 2*(NUM_PULSES+1)*HALF_DIV + 3*HALF_DIV cycles.
- R6: In the cycle of a `connect_o` pulse, `irq_o` has at most one bit set: bit c, where c is the connected channel, unless `irq_mask_i[c]` is 1 at the completing edge, in which case `irq_o` is all zeros.
- R7: `busy_o` rises only after an accepted request. A request that arrives while `busy_o` is high is ignored: the target channel, the pattern and the timing do not change.
- R8: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `connect_o` and `irq_o` are 0 and `connect_chan_o` is 0. Neither drive enable is high while `busy_o` is low.
- R9: While SCL is released within a sequence and `scl_in_i` reads low, the half-period counter holds. Each clock of such holding lengthens the sequence by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Switch request, sampled each clock |
| req_chan_i | input | CH_W | Target channel of the request |
| rec_en_i | input | 1 | 1 selects the recovery sequence, 0 gives an immediate switch |
| irq_mask_i | input | NUM_CH | Per-channel completion interrupt mask |
| scl_in_i | input | 1 | Downstream SCL level read back |
| scl_oe_o | output | 1 | Drive downstream SCL low |
| sda_oe_o | output | 1 | Drive downstream SDA low |
| busy_o | output | 1 | Sequence in progress |
| connect_o | output | 1 | One-cycle pulse: close the switch to the target channel |
| connect_chan_o | output | CH_W | Channel to be connected, held until the next completion |
| irq_o | output | NUM_CH | One-cycle completion interrupt per upstream channel |

## Verification
Two things can fall in the same cycle: a sequence finishing, and a new request from the selector. The bench keeps `req_i` high across the end of a sequence. The request seen on the completing edge must be ignored, because the block is still busy then. The request seen on the next edge, while `connect_o` pulses, must start a fresh sequence. A behavioural reference model, compared on every clock, judges the exact cycle of the `connect_o` pulse, the one idle cycle and the restart. Edge counters on the bus separately confirm the pulse count and the single STOP in each run.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } rsq_state_e;

   typedef struct packed {
      logic scl_lo;
      logic sda_lo;
   } rsq_drive_t;
endpackage

// File: rtl/rsq_half_timer.sv
module rsq_half_timer #(
   parameter int HALF_DIV   = 250,
   parameter bit STRETCH_EN = 1'b1,
   localparam int CNT_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   input  logic hold_i,
   output logic tick_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             frozen;

   generate
      if (STRETCH_EN) begin : g_stretch
         assign frozen = hold_i;
      end else begin : g_free
         logic unused_hold;
         assign unused_hold = hold_i;
         assign frozen = 1'b0;
      end
   endgenerate

   assign tick_o = run_i && !frozen && (cnt_q == CNT_W'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= '0;
      end else if (run_i && !frozen) begin
         if (tick_o) cnt_q <= '0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rsq_pattern.sv
module rsq_pattern
   import rsq_pkg::*;
#(
   parameter int NUM_PULSES = 9,
   parameter int HW         = 5
) (
   input  logic          active_i,
   input  logic [HW-1:0] half_i,
   output rsq_drive_t    drive_o,
   output logic          scl_free_o
);
   localparam int PULSE_HALVES = 2 * (NUM_PULSES + 1);

   logic in_pulses;
   logic stop_setup;
   logic stop_hold;

   assign in_pulses  = half_i < HW'(PULSE_HALVES);
   assign stop_setup = half_i == HW'(PULSE_HALVES);
   assign stop_hold  = half_i == HW'(PULSE_HALVES + 1);

   always_comb begin
      drive_o.scl_lo = active_i && ((in_pulses && !half_i[0]) || stop_setup);
      drive_o.sda_lo = active_i && (stop_setup || stop_hold);
   end

   assign scl_free_o = active_i && !drive_o.scl_lo;
endmodule

// File: rtl/i2c_recovery_seq.sv
module i2c_recovery_seq
   import rsq_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int HALF_DIV   = 250,
   parameter int NUM_PULSES = 9,
   parameter bit STRETCH_EN = 1'b1,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [CH_W-1:0]   req_chan_i,
   input  logic              rec_en_i,
   input  logic [NUM_CH-1:0] irq_mask_i,
   input  logic              scl_in_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   output logic              busy_o,
   output logic              connect_o,
   output logic [CH_W-1:0]   connect_chan_o,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int TOTAL_HALVES = 2 * (NUM_PULSES + 1) + 3;
   localparam int HW           = $clog2(TOTAL_HALVES);

   generate
      if (NUM_CH < 2)     begin : g_chk_ch  $error("NUM_CH must be at least 2"); end
      if (HALF_DIV < 2)   begin : g_chk_div $error("HALF_DIV must be at least 2"); end
      if (NUM_PULSES < 1) begin : g_chk_pul $error("NUM_PULSES must be at least 1"); end
   endgenerate

   rsq_state_e        state_q;
   logic [HW-1:0]     half_q;
   logic [CH_W-1:0]   tgt_q;
   logic              conn_q;
   logic [CH_W-1:0]   conn_ch_q;
   logic [NUM_CH-1:0] irq_q;

   logic              running;
   logic              accept;
   logic              launch;
   logic              tick;
   logic              last_half;
   logic              scl_free;
   rsq_drive_t        drive;
   logic [CH_W-1:0]   fin_ch;
   logic [NUM_CH-1:0] irq_next;

   assign running   = state_q == ST_RUN;
   assign accept    = !running && req_i;
   assign launch    = accept && rec_en_i;
   assign last_half = half_q == HW'(TOTAL_HALVES - 1);
   assign fin_ch    = running ? tgt_q : req_chan_i;

   rsq_half_timer #(
      .HALF_DIV  (HALF_DIV),
      .STRETCH_EN(STRETCH_EN)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(launch),
      .run_i  (running),
      .hold_i (scl_free && !scl_in_i),
      .tick_o (tick)
   );

   rsq_pattern #(
      .NUM_PULSES(NUM_PULSES),
      .HW        (HW)
   ) u_pattern (
      .active_i  (running),
      .half_i    (half_q),
      .drive_o   (drive),
      .scl_free_o(scl_free)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
         assign irq_next[c] = (fin_ch == CH_W'(c)) && !irq_mask_i[c];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         half_q    <= '0;
         tgt_q     <= '0;
         conn_q    <= 1'b0;
         conn_ch_q <= '0;
         irq_q     <= '0;
      end else begin
         conn_q <= 1'b0;
         irq_q  <= '0;
         if (launch) begin
            state_q <= ST_RUN;
            half_q  <= '0;
            tgt_q   <= req_chan_i;
         end else if (accept) begin
            conn_q    <= 1'b1;
            conn_ch_q <= req_chan_i;
            irq_q     <= irq_next;
         end else if (running && tick) begin
            if (last_half) begin
               state_q   <= ST_IDLE;
               conn_q    <= 1'b1;
               conn_ch_q <= tgt_q;
               irq_q     <= irq_next;
            end else begin
               half_q <= half_q + 1'b1;
            end
         end
      end
   end

   assign scl_oe_o       = drive.scl_lo;
   assign sda_oe_o       = drive.sda_lo;
   assign busy_o         = running;
   assign connect_o      = conn_q;
   assign connect_chan_o = conn_ch_q;
   assign irq_o          = irq_q;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
   parameter int NUM_CH = 2,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              scl_oe_o,
   input logic              sda_oe_o,
   input logic              busy_o,
   input logic              connect_o,
   input logic [CH_W-1:0]   connect_chan_o,
   input logic [NUM_CH-1:0] irq_o
);
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_oe_o && !sda_oe_o));

   p_sda_low_under_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> scl_oe_o);

   p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_o) |-> !scl_oe_o);

   p_finish_connects_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> connect_o);

   p_irq_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_o));

   p_irq_with_connect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_o) |-> connect_o);

   p_busy_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(req_i));

   p_chan_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(connect_chan_o));
endmodule

bind i2c_recovery_seq rsq_chk #(.NUM_CH(NUM_CH)) u_rsq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_i         (req_i),
   .scl_oe_o      (scl_oe_o),
   .sda_oe_o      (sda_oe_o),
   .busy_o        (busy_o),
   .connect_o     (connect_o),
   .connect_chan_o(connect_chan_o),
   .irq_o         (irq_o)
);

// File: tb/tb_i2c_recovery_seq.sv
`timescale 1ns/1ps
module tb_i2c_recovery_seq;
   localparam int NCH   = 2;
   localparam int DIV   = 4;
   localparam int NP    = 9;
   localparam int P2    = 2 * (NP + 1);
   localparam int HALVES = P2 + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic [0:0] chan = 1'b0;
   logic rec_en = 1'b0;
   logic [NCH-1:0] mask = '0;
   logic stretch = 1'b0;
   logic scl_oe, sda_oe, busy, conn;
   logic [0:0] conn_ch;
   logic [NCH-1:0] irq;
   logic scl_in;

   int vectors = 0;
   int errors  = 0;

   always #2.5 clk = ~clk;

   assign scl_in = !scl_oe && !stretch;

   i2c_recovery_seq #(.NUM_CH(NCH), .HALF_DIV(DIV), .NUM_PULSES(NP)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_chan_i(chan), .rec_en_i(rec_en),
      .irq_mask_i(mask), .scl_in_i(scl_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
      .busy_o(busy), .connect_o(conn), .connect_chan_o(conn_ch), .irq_o(irq));

   // behavioural reference model
   int m_busy = 0, m_h = 0, m_cnt = 0, m_tgt = 0, m_conn = 0, m_cch = 0, m_irq = 0;

   function automatic int exp_scl(int b, int h);
      return (b != 0 && ((h < P2 && h % 2 == 0) || h == P2)) ? 1 : 0;
   endfunction
   function automatic int exp_sda(int b, int h);
      return (b != 0 && (h == P2 || h == P2 + 1)) ? 1 : 0;
   endfunction
   function automatic int irq_for(int c);
      return mask[c] ? 0 : (1 << c);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 0; m_h <= 0; m_cnt <= 0; m_tgt <= 0;
         m_conn <= 0; m_cch <= 0; m_irq <= 0;
      end else begin
         m_conn <= 0;
         m_irq  <= 0;
         if (m_busy == 0) begin
            if (req) begin
               if (rec_en) begin
                  m_busy <= 1; m_h <= 0; m_cnt <= 0; m_tgt <= int'(chan);
               end else begin
                  m_conn <= 1; m_cch <= int'(chan); m_irq <= irq_for(int'(chan));
               end
            end
         end else if (!(exp_scl(m_busy, m_h) == 0 && !scl_in)) begin
            if (m_cnt == DIV - 1) begin
               m_cnt <= 0;
               if (m_h == HALVES - 1) begin
                  m_busy <= 0; m_conn <= 1; m_cch <= m_tgt; m_irq <= irq_for(m_tgt);
               end else begin
                  m_h <= m_h + 1;
               end
            end else begin
               m_cnt <= m_cnt + 1;
            end
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // edge monitors
   int scl_rel_sda_free = 0, stop_cnt = 0, bad_start = 0, busy_cycles = 0, irq_seen = 0;
   logic p_scl = 1'b0, p_sda = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 scl_oe_o", int'(scl_oe), exp_scl(m_busy, m_h));
         check("R4 sda_oe_o", int'(sda_oe), exp_sda(m_busy, m_h));
         check("R7 busy_o", int'(busy), m_busy);
         check("R5 connect_o", int'(conn), m_conn);
         check("R5 connect_chan_o", int'(conn_ch), m_cch);
         check("R6 irq_o", int'(irq), m_irq);
         if (p_scl && !scl_oe && !sda_oe) scl_rel_sda_free++;
         if (p_sda && !sda_oe && !scl_oe) stop_cnt++;
         if (!p_sda && sda_oe && !scl_oe) bad_start++;
         if (busy) busy_cycles++;
         if (|irq) irq_seen++;
      end
      p_scl = scl_oe;
      p_sda = sda_oe;
   end

   task automatic clear_mon();
      scl_rel_sda_free = 0; stop_cnt = 0; bad_start = 0; busy_cycles = 0; irq_seen = 0;
   endtask

   task automatic pulse_req(input logic c, input logic en);
      @(negedge clk);
      req = 1'b1; chan = c; rec_en = en;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            check("R8 scl_oe_o in reset", int'(scl_oe), 0);
            rst_n = 1'b1;
            @(negedge clk);
            check("R8 busy_o after reset", int'(busy), 0);
            check("R8 connect_chan_o after reset", int'(conn_ch), 0);
            check("R8 irq_o after reset", int'(irq), 0);

            // R1 bypass
            clear_mon();
            pulse_req(1'b1, 1'b0);
            check("R1 connect_o pulse", int'(conn), 1);
            check("R1 connect_chan_o", int'(conn_ch), 1);
            check("R1 busy_o stays low", int'(busy), 0);
            @(negedge clk);
            check("R1 connect_o single cycle", int'(conn), 0);

            // R2 R3 R4 R5 full sequence to channel 0
            clear_mon();
            pulse_req(1'b0, 1'b1);
            wait_done();
            check("R2 R3 released SCL pulses", scl_rel_sda_free, NP + 1);
            check("R4 stop count", stop_cnt, 1);
            check("R4 no start while SCL high", bad_start, 0);
            check("R5 busy duration", busy_cycles, HALVES * DIV);
            check("R6 irq raised", irq_seen, 1);
            check("R5 connected channel", int'(conn_ch), 0);

            // R7 ignored request while busy
            clear_mon();
            pulse_req(1'b1, 1'b1);
            repeat (10) @(negedge clk);
            req = 1'b1; chan = 1'b0; rec_en = 1'b0;
            @(negedge clk);
            req = 1'b0;
            wait_done();
            check("R7 target kept", int'(conn_ch), 1);
            check("R7 timing unchanged", busy_cycles, HALVES * DIV);

            // R6 masked interrupt
            clear_mon();
            mask = 2'b10;
            pulse_req(1'b1, 1'b1);
            wait_done();
            check("R6 masked irq", irq_seen, 0);
            mask = 2'b00;

            // R9 stretch
            clear_mon();
            pulse_req(1'b0, 1'b1);
            while (scl_oe) @(negedge clk);
            stretch = 1'b1;
            repeat (10) @(negedge clk);
            stretch = 1'b0;
            wait_done();
            check("R9 stretched duration", busy_cycles, HALVES * DIV + 10);

            // R7 request held across completion
            clear_mon();
            @(negedge clk);
            req = 1'b1; chan = 1'b1; rec_en = 1'b1;
            @(negedge clk);
            while (busy) @(negedge clk);
            check("R5 connect at finish", int'(conn), 1);
            @(negedge clk);
            check("R7 restart after finish", int'(busy), 1);
            req = 1'b0;
            wait_done();
            check("R7 two runs", busy_cycles, 2 * HALVES * DIV);
            repeat (4) @(negedge clk);
         end
         begin
            repeat (100000) @(posedge clk);
            errors++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=finished");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule